// File: doc/BRIEF.md
# Operand Fetch Bus Sequencer

This block steps an 8-bit processor's bus through the operand fetch of one instruction. It follows the exact cycle pattern of each addressing mode, including the internal idle cycles where they fall. A start pulse, given while the block is free, latches four things:

- a mode code,
- the program counter,
- the two index registers,
- a direct-page select bit.

From the next clock on, the block drives one bus cycle per clock. Each cycle is either a read at a computed address or an idle cycle with the strobe low. The read data bus is combinational: a byte placed on it during a read cycle is taken at the closing clock edge.

When the last bus cycle of the mode ends, the block raises `done` for one clock. At the same time `operand` takes the byte fetched for the instruction. The ALU and the write-back logic take it from there. A new start may be given in the same cycle as `done`, so fetches can run back to back.

Top module: `opfetch_seq`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `bus_rd` and `bus_idle` are 0, `bus_addr` is 0x0000 and `operand` is 0x00.
- R2: The first bus cycle of every mode is a read at the latched PC. A start pulse while `busy` is 1 has no effect on the running sequence.
- R3: The mode code fixes the cycle pattern (R = read, I = idle).
  - Mode 0 (immediate) reads PC, then PC+1, and the operand is the byte at PC+1.
  - Mode 1 (register move) is PC read, then one idle cycle, and the operand is the latched X value.
- R4: The direct base address is {7'b0, dp_sel, off}, where off is the byte read at PC+1.
  - Mode 2 is R(PC), R(PC+1), R(base).
  - Mode 3 is R(PC), R(PC+1), I, R(base+index), where the index is Y when `idx_y` is 1 and X otherwise.
- R5: Mode 4 is R(PC), I, R({7'b0, dp_sel, X}). Mode 5 is the same with one more trailing idle cycle. In both, the operand is the byte read at the X address.
- R6: Mode 6 is R(PC), R(PC+1), I, R(base+X), R(base+X+1), R(pointer). The pointer is {byte at base+X+1, byte at base+X}.
- R7: Mode 7 is R(PC), R(PC+1), R(base), R(base+1), I, R(pointer+Y). The pointer is {byte at base+1, byte at base}.
- R8: Absolute modes
  - Mode 8 is R(PC), R(PC+1), R(PC+2), R(address), where the address is {byte at PC+2, byte at PC+1}.
  - Mode 9 inserts an idle cycle before the data read, which goes to address+index, with the index chosen by `idx_y`.
- R9: An idle cycle has `bus_idle`=1, `bus_rd`=0 and `bus_addr`=0x0000. `bus_rd` and `bus_idle` are never 1 together, and both are 0 while the block is not busy.
- R10: `done` is a single-cycle pulse in the clock after the last bus cycle, with `busy` already 0. `operand` then holds the mode's fetched byte until the next `done`.
- R11: All address sums (base+index, base+X+1, pointer+Y, PC+2, absolute+index) wrap modulo 2^16.
- R12: Mode codes 10 to 15 behave exactly as mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a fetch (taken when not busy) |
| mode | input | 4 | Addressing mode code |
| pc | input | 16 | Opcode address |
| x_in | input | 8 | X index register |
| y_in | input | 8 | Y index register |
| dp_sel | input | 1 | Direct-page select (high byte 0x00 or 0x01) |
| idx_y | input | 1 | Index choice for modes 3 and 9: 1 = Y |
| rdata | input | 8 | Read data bus, valid during read cycles |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_idle | output | 1 | Internal idle cycle flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Fetch complete pulse |
| operand | output | 8 | Fetched operand byte |

## Verification
The assertions watch the properties that hold on every clock:
- strobe and idle flag are exclusive, and an idle cycle carries a zero address;
- the bus is quiet whenever the block is not busy;
- the first cycle addresses the latched PC;
- the step count advances by one per cycle no matter what `start` does;
- `done` is a lone pulse that follows the end of `busy`.

The per-mode cycle count, the place of each idle cycle, the address of every read and the operand value can only be shown by the bench's scenarios. The bench models the memory and rebuilds every expected trace from the mode rules, including index choice, page select and address wrap.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int STEP_W = 3;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MD_IMM    = 4'd0;
  localparam logic [MODE_W-1:0] MD_REG    = 4'd1;
  localparam logic [MODE_W-1:0] MD_DIR    = 4'd2;
  localparam logic [MODE_W-1:0] MD_DIRX   = 4'd3;
  localparam logic [MODE_W-1:0] MD_INDX   = 4'd4;
  localparam logic [MODE_W-1:0] MD_INDXP  = 4'd5;
  localparam logic [MODE_W-1:0] MD_PREIDX = 4'd6;
  localparam logic [MODE_W-1:0] MD_POSTIX = 4'd7;
  localparam logic [MODE_W-1:0] MD_ABS    = 4'd8;
  localparam logic [MODE_W-1:0] MD_ABSX   = 4'd9;

  typedef enum logic [2:0] {
    K_NONE, K_OPC, K_OFF, K_IDLE, K_PLO, K_PHI, K_DATA
  } kind_e;

  function automatic logic [MODE_W-1:0] norm_mode(input logic [MODE_W-1:0] m);
    return (m > MD_ABSX) ? MD_REG : m;
  endfunction

  function automatic logic [STEP_W-1:0] mode_len(input logic [MODE_W-1:0] m);
    case (m)
      MD_IMM, MD_REG:        return 3'd2;
      MD_DIR, MD_INDX:       return 3'd3;
      MD_DIRX, MD_INDXP,
      MD_ABS:                return 3'd4;
      MD_ABSX:               return 3'd5;
      MD_PREIDX, MD_POSTIX:  return 3'd6;
      default:               return 3'd2;
    endcase
  endfunction

  function automatic kind_e step_kind(input logic [MODE_W-1:0] m,
                                      input logic [STEP_W-1:0] s);
    if (s == 3'd1) return K_OPC;
    case (m)
      MD_IMM:   return K_DATA;
      MD_DIR:   return (s == 3'd2) ? K_OFF : K_DATA;
      MD_DIRX:  case (s) 3'd2: return K_OFF; 3'd3: return K_IDLE; default: return K_DATA; endcase
      MD_INDX:  return (s == 3'd2) ? K_IDLE : K_DATA;
      MD_INDXP: return (s == 3'd3) ? K_DATA : K_IDLE;
      MD_PREIDX:
        case (s)
          3'd2: return K_OFF;  3'd3: return K_IDLE;
          3'd4: return K_PLO;  3'd5: return K_PHI;
          default: return K_DATA;
        endcase
      MD_POSTIX:
        case (s)
          3'd2: return K_OFF;  3'd3: return K_PLO;
          3'd4: return K_PHI;  3'd5: return K_IDLE;
          default: return K_DATA;
        endcase
      MD_ABS:   case (s) 3'd2: return K_PLO; 3'd3: return K_PHI; default: return K_DATA; endcase
      MD_ABSX:
        case (s)
          3'd2: return K_PLO;  3'd3: return K_PHI;
          3'd4: return K_IDLE; default: return K_DATA;
        endcase
      default:  return K_IDLE;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] page_addr(input logic dp, input logic [DATA_W-1:0] lo);
    return {{(ADDR_W-DATA_W-1){1'b0}}, dp, lo};
  endfunction

  function automatic logic [ADDR_W-1:0] add_byte(input logic [ADDR_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + {{(ADDR_W-DATA_W){1'b0}}, b};
  endfunction
endpackage

// File: rtl/opfetch_ctrl.sv
module opfetch_ctrl
  import opfetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_in,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic [MODE_W-1:0] mode_q,
  output kind_e             kind,
  output logic              last,
  output logic              accept,
  output logic              done
);
  assign accept = start && !busy;
  assign kind   = busy ? step_kind(mode_q, step) : K_NONE;
  assign last   = busy && (step == mode_len(mode_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step   <= '0;
      mode_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        busy   <= 1'b1;
        step   <= 3'd1;
        mode_q <= norm_mode(mode_in);
      end else if (last) begin
        busy <= 1'b0;
        step <= '0;
      end else if (busy) begin
        step <= step + 3'd1;
      end
    end
  end

  // R2: a start while busy does not disturb the step sequence
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && step == $past(step) + 3'd1));
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/opfetch_capture.sv
module opfetch_capture
  import opfetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              last,
  input  kind_e             kind,
  input  logic [MODE_W-1:0] mode_q,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  input  logic              dp_sel,
  input  logic              idx_y,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] x_q,
  output logic [DATA_W-1:0] y_q,
  output logic              dp_q,
  output logic              idxy_q,
  output logic [DATA_W-1:0] off_q,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [DATA_W-1:0] operand
);
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] result;

  always_comb begin
    if (kind == K_DATA)      result = rdata;
    else if (mode_q == MD_REG) result = x_q;
    else                     result = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0; x_q <= '0; y_q <= '0; dp_q <= 1'b0; idxy_q <= 1'b0;
      off_q <= '0; ptr_q <= '0; data_q <= '0; operand <= '0;
    end else begin
      if (accept) begin
        pc_q <= pc; x_q <= x_in; y_q <= y_in; dp_q <= dp_sel; idxy_q <= idx_y;
      end
      case (kind)
        K_OFF:  off_q <= rdata;
        K_PLO:  ptr_q[DATA_W-1:0] <= rdata;
        K_PHI:  ptr_q[ADDR_W-1:DATA_W] <= rdata;
        K_DATA: data_q <= rdata;
        default: ;
      endcase
      if (last) operand <= result;
    end
  end
endmodule

// File: rtl/opfetch_addr.sv
module opfetch_addr
  import opfetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  kind_e             kind,
  input  logic [MODE_W-1:0] mode_q,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [DATA_W-1:0] x_q,
  input  logic [DATA_W-1:0] y_q,
  input  logic              dp_q,
  input  logic              idxy_q,
  input  logic [DATA_W-1:0] off_q,
  input  logic [ADDR_W-1:0] ptr_q,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_idle
);
  logic [ADDR_W-1:0] base;
  logic [DATA_W-1:0] idx;
  logic              is_abs;

  assign base   = page_addr(dp_q, off_q);
  assign idx    = idxy_q ? y_q : x_q;
  assign is_abs = (mode_q == MD_ABS) || (mode_q == MD_ABSX);

  always_comb begin
    bus_addr = '0;
    case (kind)
      K_OPC:  bus_addr = pc_q;
      K_OFF:  bus_addr = add_byte(pc_q, 8'd1);
      K_PLO:  bus_addr = is_abs ? add_byte(pc_q, 8'd1)
                       : (mode_q == MD_PREIDX) ? add_byte(base, x_q) : base;
      K_PHI:  bus_addr = is_abs ? add_byte(pc_q, 8'd2)
                       : (mode_q == MD_PREIDX) ? add_byte(add_byte(base, x_q), 8'd1)
                       : add_byte(base, 8'd1);
      K_DATA:
        case (mode_q)
          MD_IMM:             bus_addr = add_byte(pc_q, 8'd1);
          MD_DIR:             bus_addr = base;
          MD_DIRX:            bus_addr = add_byte(base, idx);
          MD_INDX, MD_INDXP:  bus_addr = page_addr(dp_q, x_q);
          MD_POSTIX:          bus_addr = add_byte(ptr_q, y_q);
          MD_ABSX:            bus_addr = add_byte(ptr_q, idx);
          default:            bus_addr = ptr_q;
        endcase
      default: bus_addr = '0;
    endcase
  end

  assign bus_rd   = (kind != K_NONE) && (kind != K_IDLE);
  assign bus_idle = (kind == K_IDLE);

  a_r9_rd_idle_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_idle));
  a_r9_idle_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> (bus_addr == '0));
endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
  import opfetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  input  logic              dp_sel,
  input  logic              idx_y,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_idle,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] operand
);
  logic [STEP_W-1:0] step;
  logic [MODE_W-1:0] mode_q;
  kind_e             kind;
  logic              last, accept;
  logic [ADDR_W-1:0] pc_q, ptr_q;
  logic [DATA_W-1:0] x_q, y_q, off_q;
  logic              dp_q, idxy_q;

  opfetch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
    .busy(busy), .step(step), .mode_q(mode_q), .kind(kind),
    .last(last), .accept(accept), .done(done)
  );

  opfetch_capture u_cap (
    .clk(clk), .rst_n(rst_n), .accept(accept), .last(last), .kind(kind),
    .mode_q(mode_q), .pc(pc), .x_in(x_in), .y_in(y_in), .dp_sel(dp_sel),
    .idx_y(idx_y), .rdata(rdata), .pc_q(pc_q), .x_q(x_q), .y_q(y_q),
    .dp_q(dp_q), .idxy_q(idxy_q), .off_q(off_q), .ptr_q(ptr_q),
    .operand(operand)
  );

  opfetch_addr u_addr (
    .clk(clk), .rst_n(rst_n), .kind(kind), .mode_q(mode_q), .pc_q(pc_q),
    .x_q(x_q), .y_q(y_q), .dp_q(dp_q), .idxy_q(idxy_q), .off_q(off_q),
    .ptr_q(ptr_q), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_idle(bus_idle)
  );

  a_r2_first_cycle_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step == 3'd1) |-> (bus_rd && bus_addr == pc_q));
  a_r9_quiet_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_rd && !bus_idle));
endmodule

// File: tb/opfetch_seq_tb.sv
module opfetch_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  x_in = '0, y_in = '0;
  logic        dp_sel = 1'b0, idx_y = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_idle, busy, done;
  logic [7:0]  operand;

  int checks = 0;
  int errors = 0;
  int n;
  logic [15:0] ea [8];
  bit          er [8];

  always #10 clk = ~clk;

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
  endfunction

  always_comb rdata = mb(bus_addr);

  opfetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc(pc),
    .x_in(x_in), .y_in(y_in), .dp_sel(dp_sel), .idx_y(idx_y), .rdata(rdata),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_idle(bus_idle), .busy(busy),
    .done(done), .operand(operand)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input bit rd);
    ea[n] = a; er[n] = rd; n++;
  endtask

  task automatic run_case(input string tag, input logic [3:0] m, input logic [15:0] p,
                          input logic [7:0] xv, input logic [7:0] yv,
                          input logic dps, input logic idy, input bit poke);
    logic [7:0] off, ix, opv;
    logic [15:0] b, t, ptr;
    ix = idy ? yv : xv;
    off = mb(p + 16'd1);
    b = {7'd0, dps, off};
    n = 0;
    push(p, 1'b1);
    opv = xv;
    case (m)
      4'd0: begin push(p + 16'd1, 1); opv = mb(p + 16'd1); end
      4'd2: begin push(p + 16'd1, 1); push(b, 1); opv = mb(b); end
      4'd3: begin t = b + {8'd0, ix}; push(p + 16'd1, 1); push(16'd0, 0); push(t, 1); opv = mb(t); end
      4'd4, 4'd5: begin
        t = {7'd0, dps, xv};
        push(16'd0, 0); push(t, 1); opv = mb(t);
        if (m == 4'd5) push(16'd0, 0);
      end
      4'd6: begin
        t = b + {8'd0, xv};
        push(p + 16'd1, 1); push(16'd0, 0); push(t, 1); push(t + 16'd1, 1);
        ptr = {mb(t + 16'd1), mb(t)}; push(ptr, 1); opv = mb(ptr);
      end
      4'd7: begin
        push(p + 16'd1, 1); push(b, 1); push(b + 16'd1, 1); push(16'd0, 0);
        ptr = {mb(b + 16'd1), mb(b)} + {8'd0, yv}; push(ptr, 1); opv = mb(ptr);
      end
      4'd8, 4'd9: begin
        push(p + 16'd1, 1); push(p + 16'd2, 1);
        ptr = {mb(p + 16'd2), mb(p + 16'd1)};
        if (m == 4'd9) begin push(16'd0, 0); ptr = ptr + {8'd0, ix}; end
        push(ptr, 1); opv = mb(ptr);
      end
      default: begin push(16'd0, 0); opv = xv; end
    endcase

    @(negedge clk);
    mode = m; pc = p; x_in = xv; y_in = yv; dp_sel = dps; idx_y = idy; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i == 0) chk(bus_addr == p && bus_rd, "R2 first cycle reads PC", bus_addr, p);
      chk(bus_addr == ea[i], $sformatf("%s addr cycle %0d", tag, i + 1), bus_addr, ea[i]);
      chk(bus_rd == er[i], $sformatf("%s strobe cycle %0d", tag, i + 1), bus_rd, er[i]);
      chk(bus_idle == !er[i], $sformatf("R9 idle flag cycle %0d (%s)", i + 1, tag), bus_idle, !er[i]);
      chk(busy && !done, $sformatf("R10 busy without done cycle %0d", i + 1), {busy, done}, 2'b10);
      if (poke && i == 1) begin
        start = 1'b1; mode = 4'd0; pc = p ^ 16'h5555; x_in = ~xv;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk(done && !busy, $sformatf("R10 done pulse after %s", tag), {done, busy}, 2'b10);
    chk(operand == opv, $sformatf("%s operand", tag), operand, opv);
    @(negedge clk);
    chk(!done, "R10 done is one cycle", done, 0);
    chk(operand == opv, "R10 operand held", operand, opv);
    chk(!bus_rd && !bus_idle && bus_addr == 16'd0, "R9 quiet when free", {bus_rd, bus_idle}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(!busy && !done && !bus_rd && !bus_idle && bus_addr == 0 && operand == 0,
        "R1 reset state", {busy, done, bus_rd, bus_idle}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && bus_addr == 0 && operand == 0, "R1 after reset release",
        {busy, done, bus_addr}, 0);

    run_case("R3 immediate",       4'd0, 16'h1234, 8'h11, 8'h22, 1'b0, 1'b0, 1'b0);
    run_case("R3 register move",   4'd1, 16'h2000, 8'h5A, 8'h22, 1'b0, 1'b0, 1'b0);
    run_case("R4 direct page0",    4'd2, 16'h0310, 8'h01, 8'h02, 1'b0, 1'b0, 1'b0);
    run_case("R4 direct page1",    4'd2, 16'h0310, 8'h01, 8'h02, 1'b1, 1'b0, 1'b0);
    run_case("R4 direct+X",        4'd3, 16'h4000, 8'h13, 8'h70, 1'b0, 1'b0, 1'b0);
    run_case("R4 direct+Y",        4'd3, 16'h4000, 8'h13, 8'h70, 1'b1, 1'b1, 1'b0);
    run_case("R5 indirect X",      4'd4, 16'h5000, 8'h9C, 8'h00, 1'b1, 1'b0, 1'b0);
    run_case("R5 indirect X post", 4'd5, 16'h5001, 8'h3D, 8'h00, 1'b0, 1'b0, 1'b0);
    run_case("R6 indexed indirect", 4'd6, 16'h6002, 8'h21, 8'h00, 1'b0, 1'b0, 1'b0);
    run_case("R7 indirect indexed", 4'd7, 16'h7003, 8'h00, 8'h44, 1'b1, 1'b0, 1'b0);
    run_case("R8 absolute",        4'd8, 16'h8004, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    run_case("R8 absolute+X",      4'd9, 16'h9005, 8'h80, 8'h07, 1'b0, 1'b0, 1'b0);
    run_case("R8 absolute+Y",      4'd9, 16'h9005, 8'h80, 8'h07, 1'b0, 1'b1, 1'b0);
    run_case("R2 start ignored while busy", 4'd6, 16'h0A0B, 8'h33, 8'h00, 1'b1, 1'b0, 1'b1);
    run_case("R11 wrap page index", 4'd6, 16'hC0FD, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0);
    run_case("R11 wrap pointer+Y",  4'd7, 16'hFFF0, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0);
    run_case("R11 wrap PC+2",       4'd9, 16'hFFFE, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0);
    run_case("R12 unsupported code", 4'd13, 16'h1111, 8'hA7, 8'h00, 1'b0, 1'b0, 1'b0);
    run_case("R12 unsupported code 15", 4'd15, 16'h2222, 8'h4E, 8'h00, 1'b1, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule